// File: doc/BRIEF.md
# Time-of-day and calendar counter

This block holds the current time and date as a small file of byte registers: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A single-cycle pulse on `tick_1s`, produced by a prescaler outside the block, steps the time forward by one second. Carries ripple through minutes, hours, day, date, month and year in the same step. Date rollover follows the length of each month and the leap-year rule for February.

Two static mode inputs choose how every field is coded. `bcd_mode` selects packed decimal or plain binary. `hr12_mode` selects a 12-hour clock, with bit 7 of the hours byte as the afternoon flag, or a 24-hour clock. The block also holds alarm bytes for seconds, minutes and hours. It emits a one-cycle `alarm_evt` when a tick brings the time to a value the alarm matches. An alarm byte whose two top bits are both set matches any value, so the alarm can fire every second, minute or hour, or once a day.

Software reads and writes the register file through a plain address/data port. Nothing converts stored values when a mode input changes: software rewrites the fields in the new coding.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, seconds, minutes, hours, year and the three alarm bytes read 0x00, day of week, date and month read 0x01, and `alarm_evt` is low.
- R2: The register map is fixed. Address 0 holds seconds, 1 the seconds alarm, 2 minutes, 3 the minutes alarm, 4 hours, 5 the hours alarm, 6 day of week, 7 date, 8 month and 9 year. A write with `wr_en` high stores `wr_data` at `addr` on the next clock edge. `rd_data` shows the addressed register in the same cycle. Addresses 10 to 15 read 0x00 and writes to them change nothing.
- R3: Time changes only on a cycle with `tick_1s` high, by exactly one second. Seconds and minutes wrap from 59 to 0 and carry. The value 59 is coded 0x3B in binary and 0x59 in BCD.
- R4: In 24-hour mode, hours wrap from 23 to 0 and carry into the day. The value 23 is coded 0x17 in binary and 0x23 in BCD.
- R5: In 12-hour mode, hours run 1 to 12 in bits 6:0, and bit 7 set means afternoon. Going from 11 to 12 toggles bit 7. Going from 12 to 1 keeps bit 7. Going from 11 in the afternoon to 12 in the morning carries into the day.
- R6: On a day carry, day of week steps by one and wraps from 7 to 1.
- R7: On a day carry, the date wraps to 1 after day 30 for months 4, 6, 9 and 11, and after day 31 for the other months. February wraps after day 29 when the year is a multiple of 4, and after day 28 otherwise. The month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0.
- R8: `alarm_evt` is high for one cycle after a tick edge whose new seconds, minutes and hours each equal their alarm byte, or whose alarm byte has bits 7:6 equal to 11. It is low after every other edge.
- R9: When a write and a tick fall in the same cycle, the addressed register takes `wr_data` and every other time field advances as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle pulse per second |
| bcd_mode | input | 1 | 1 = BCD coding, 0 = binary |
| hr12_mode | input | 1 | 1 = 12-hour clock, 0 = 24-hour |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| alarm_evt | output | 1 | One-cycle alarm match pulse |

## Verification
A write lands at the first rising edge that sees `wr_en`. `rd_data` is combinational, so it is valid after `addr` settles in the same cycle. The time step and `alarm_evt` are both produced at the edge that samples `tick_1s`. The bench therefore reads the fields and samples `alarm_evt` at the falling edge right after that edge. It checks that `alarm_evt` is low again one cycle later.

// File: rtl/rtc_calendar.sv
module rtc_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1s,
  input  logic       bcd_mode,
  input  logic       hr12_mode,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       alarm_evt
);

  logic [7:0] sec_q, min_q, hr_q, dow_q, date_q, mon_q, yr_q;
  logic [7:0] sal_q, mal_q, hal_q;
  logic [7:0] sec_d, min_d, hr_d, dow_d, date_d, mon_d, yr_d;
  logic [7:0] sal_d, mal_d, hal_d;
  logic [7:0] a_sec, a_min, a_hr, a_dow, a_date, a_mon, a_yr;
  logic [7:0] sb, mb, hb, wb, db, mob, yb, mlen;
  logic       c_min, c_hr, c_day, c_mon, c_yr;

  function automatic logic [7:0] dec(input logic [7:0] v, input logic b);
    return b ? ({4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]}) : v;
  endfunction

  function automatic logic [7:0] enc(input logic [7:0] n, input logic b);
    logic [7:0] t, o;
    t = n / 8'd10;
    o = n % 8'd10;
    return b ? {t[3:0], o[3:0]} : n;
  endfunction

  function automatic logic [7:0] hr12(input logic pm, input logic [7:0] n, input logic b);
    logic [7:0] e;
    e = enc(n, b);
    return {pm, e[6:0]};
  endfunction

  function automatic logic alm(input logic [7:0] al, input logic [7:0] v);
    return (al[7:6] == 2'b11) || (al == v);
  endfunction

  always_comb begin
    sb  = dec(sec_q, bcd_mode);
    mb  = dec(min_q, bcd_mode);
    hb  = hr12_mode ? dec({1'b0, hr_q[6:0]}, bcd_mode) : dec(hr_q, bcd_mode);
    wb  = dec(dow_q, bcd_mode);
    db  = dec(date_q, bcd_mode);
    mob = dec(mon_q, bcd_mode);
    yb  = dec(yr_q, bcd_mode);

    case (mob)
      8'd2:                      mlen = (yb[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   mlen = 8'd30;
      default:                   mlen = 8'd31;
    endcase

    c_min = (sb >= 8'd59);
    a_sec = c_min ? 8'd0 : enc(sb + 8'd1, bcd_mode);

    c_hr  = c_min && (mb >= 8'd59);
    a_min = !c_min ? min_q : (c_hr ? 8'd0 : enc(mb + 8'd1, bcd_mode));

    a_hr  = hr_q;
    c_day = 1'b0;
    if (c_hr) begin
      if (hr12_mode) begin
        if (hb == 8'd11) begin
          a_hr  = hr12(~hr_q[7], 8'd12, bcd_mode);
          c_day = hr_q[7];
        end else if (hb >= 8'd12 || hb == 8'd0) begin
          a_hr = hr12(hr_q[7], 8'd1, bcd_mode);
        end else begin
          a_hr = hr12(hr_q[7], hb + 8'd1, bcd_mode);
        end
      end else if (hb >= 8'd23) begin
        a_hr  = 8'd0;
        c_day = 1'b1;
      end else begin
        a_hr = enc(hb + 8'd1, bcd_mode);
      end
    end

    a_dow = !c_day ? dow_q :
            ((wb >= 8'd7 || wb == 8'd0) ? enc(8'd1, bcd_mode) : enc(wb + 8'd1, bcd_mode));

    c_mon  = c_day && (db >= mlen);
    a_date = !c_day ? date_q : (c_mon ? enc(8'd1, bcd_mode) : enc(db + 8'd1, bcd_mode));

    c_yr  = c_mon && (mob >= 8'd12);
    a_mon = !c_mon ? mon_q : (c_yr ? enc(8'd1, bcd_mode) : enc(mob + 8'd1, bcd_mode));

    a_yr  = !c_yr ? yr_q : ((yb >= 8'd99) ? 8'd0 : enc(yb + 8'd1, bcd_mode));
  end

  assign sec_d  = (wr_en && addr == 4'd0) ? wr_data : (tick_1s ? a_sec  : sec_q);
  assign sal_d  = (wr_en && addr == 4'd1) ? wr_data : sal_q;
  assign min_d  = (wr_en && addr == 4'd2) ? wr_data : (tick_1s ? a_min  : min_q);
  assign mal_d  = (wr_en && addr == 4'd3) ? wr_data : mal_q;
  assign hr_d   = (wr_en && addr == 4'd4) ? wr_data : (tick_1s ? a_hr   : hr_q);
  assign hal_d  = (wr_en && addr == 4'd5) ? wr_data : hal_q;
  assign dow_d  = (wr_en && addr == 4'd6) ? wr_data : (tick_1s ? a_dow  : dow_q);
  assign date_d = (wr_en && addr == 4'd7) ? wr_data : (tick_1s ? a_date : date_q);
  assign mon_d  = (wr_en && addr == 4'd8) ? wr_data : (tick_1s ? a_mon  : mon_q);
  assign yr_d   = (wr_en && addr == 4'd9) ? wr_data : (tick_1s ? a_yr   : yr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q     <= 8'h00;
      min_q     <= 8'h00;
      hr_q      <= 8'h00;
      dow_q     <= 8'h01;
      date_q    <= 8'h01;
      mon_q     <= 8'h01;
      yr_q      <= 8'h00;
      sal_q     <= 8'h00;
      mal_q     <= 8'h00;
      hal_q     <= 8'h00;
      alarm_evt <= 1'b0;
    end else begin
      sec_q     <= sec_d;
      min_q     <= min_d;
      hr_q      <= hr_d;
      dow_q     <= dow_d;
      date_q    <= date_d;
      mon_q     <= mon_d;
      yr_q      <= yr_d;
      sal_q     <= sal_d;
      mal_q     <= mal_d;
      hal_q     <= hal_d;
      alarm_evt <= tick_1s && alm(sal_d, sec_d) && alm(mal_d, min_d) && alm(hal_d, hr_d);
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rd_data = sec_q;
      4'd1:    rd_data = sal_q;
      4'd2:    rd_data = min_q;
      4'd3:    rd_data = mal_q;
      4'd4:    rd_data = hr_q;
      4'd5:    rd_data = hal_q;
      4'd6:    rd_data = dow_q;
      4'd7:    rd_data = date_q;
      4'd8:    rd_data = mon_q;
      4'd9:    rd_data = yr_q;
      default: rd_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1s,
  input logic       bcd_mode,
  input logic       hr12_mode,
  input logic       wr_en,
  input logic [3:0] addr,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       alarm_evt,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hr_q
);

  logic [7:0] smax;
  logic [6:0] h11;
  assign smax = bcd_mode ? 8'h59 : 8'h3B;
  assign h11  = bcd_mode ? 7'h11 : 7'h0B;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1s && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q))); // R3

  AST_WRITE_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd0) |=> (sec_q == $past(wr_data))); // R2

  AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 4'd10) |-> (rd_data == 8'h00)); // R2

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && !(wr_en && addr == 4'd0) && sec_q == smax) |=> (sec_q == 8'h00)); // R3

  AST_PM_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && hr12_mode && !wr_en && sec_q == smax && min_q == smax && hr_q[6:0] == h11)
    |=> (hr_q[7] != $past(hr_q[7]))); // R5

  AST_ALARM_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |-> $past(tick_1s)); // R8

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .bcd_mode(bcd_mode),
  .hr12_mode(hr12_mode), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .alarm_evt(alarm_evt), .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1s = 1'b0;
  logic       bcd_mode = 1'b0;
  logic       hr12_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       alarm_evt;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  rtc_calendar u_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .bcd_mode(bcd_mode),
    .hr12_mode(hr12_mode), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .alarm_evt(alarm_evt)
  );

  // {bcd, h12, start sec,min,hr,dow,date,mon,yr, expected after one tick}
  localparam logic [113:0] VEC [0:12] = '{
    {2'b00, 56'h3B3B17071F0C63, 56'h00000001010100}, // R3 R4 R6 R7 binary full rollover
    {2'b10, 56'h59592307311299, 56'h00000001010100}, // R3 R4 R6 R7 BCD full rollover
    {2'b10, 56'h58001003150624, 56'h59001003150624}, // R3 plain step
    {2'b00, 56'h3B0502021E0405, 56'h000602021E0405}, // R3 minute carry
    {2'b11, 56'h59591102100324, 56'h00009202100324}, // R5 11 AM -> 12 PM
    {2'b11, 56'h59599202100324, 56'h00008102100324}, // R5 12 PM -> 1 PM
    {2'b11, 56'h59599102100324, 56'h00001203110324}, // R5 R6 11 PM -> 12 AM
    {2'b01, 56'h3B3B8B041C0205, 56'h00000C05010305}, // R5 R7 Feb 28 non-leap
    {2'b10, 56'h59592305280224, 56'h00000006290224}, // R7 Feb 28 leap
    {2'b10, 56'h59592306290224, 56'h00000007010324}, // R7 R6 Feb 29 leap
    {2'b10, 56'h59592301300424, 56'h00000002010524}, // R7 30-day month
    {2'b00, 56'h3B3B17011E0100, 56'h000000021F0100}, // R7 Jan 30 -> 31
    {2'b01, 56'h3B3B0C01010100, 56'h00000101010100}  // R5 12 AM -> 1 AM
  };

  localparam logic [3:0] TADDR [0:6] = '{4'd0, 4'd2, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9};

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1s = 1'b1;
    @(negedge clk);
    tick_1s = 1'b0;
  endtask

  task automatic read_time(output logic [55:0] t);
    logic [7:0] b;
    for (int j = 0; j < 7; j++) begin
      rd(TADDR[j], b);
      t[55 - 8*j -: 8] = b;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1..: actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [55:0] t;
    logic [113:0] v;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_time(t);
    chk({8'd0, t}, {8'd0, 56'h00000001010100}, "R1 time after reset");
    rd(4'd1, b); chk({56'd0, b}, 64'h0, "R1 seconds alarm");
    rd(4'd3, b); chk({56'd0, b}, 64'h0, "R1 minutes alarm");
    rd(4'd5, b); chk({56'd0, b}, 64'h0, "R1 hours alarm");
    chk({63'd0, alarm_evt}, 64'h0, "R1 alarm_evt");

    // R2 high addresses read zero and ignore writes
    wr(4'd12, 8'hA5);
    rd(4'd12, b); chk({56'd0, b}, 64'h0, "R2 addr 12 reads zero");
    read_time(t);
    chk({8'd0, t}, {8'd0, 56'h00000001010100}, "R2 write to addr 12 ignored");
    wr(4'd3, 8'h2A);
    rd(4'd3, b); chk({56'd0, b}, 64'h2A, "R2 minutes alarm write");

    // Park alarms on wildcard-free values that do not interfere
    wr(4'd1, 8'h3F); wr(4'd3, 8'h3F); wr(4'd5, 8'h3F);

    for (int i = 0; i < 13; i++) begin
      v = VEC[i];
      bcd_mode = v[113];
      hr12_mode = v[112];
      for (int j = 0; j < 7; j++) wr(TADDR[j], v[111 - 8*j -: 8]);
      tick();
      read_time(t);
      chk({8'd0, t}, {8'd0, v[55:0]}, $sformatf("R3-R7 vector %0d time", i));
    end

    // R3 no advance without tick
    bcd_mode = 1'b1; hr12_mode = 1'b0;
    wr(4'd0, 8'h05); wr(4'd2, 8'h10); wr(4'd4, 8'h08);
    repeat (5) @(negedge clk);
    rd(4'd0, b); chk({56'd0, b}, 64'h05, "R3 seconds hold without tick");

    // R9 write and tick in the same cycle
    @(negedge clk);
    tick_1s = 1'b1; wr_en = 1'b1; addr = 4'd2; wr_data = 8'h20;
    @(negedge clk);
    tick_1s = 1'b0; wr_en = 1'b0;
    rd(4'd0, b); chk({56'd0, b}, 64'h06, "R9 seconds advance beside write");
    rd(4'd2, b); chk({56'd0, b}, 64'h20, "R9 minutes take write data");

    // R8 wildcard on minutes and hours: time 08:20:06 BCD
    wr(4'd1, 8'h07); wr(4'd3, 8'hC0); wr(4'd5, 8'hC0);
    tick();
    chk({63'd0, alarm_evt}, 64'h1, "R8 alarm with wildcards");
    @(negedge clk);
    chk({63'd0, alarm_evt}, 64'h0, "R8 alarm one cycle only");
    tick();
    chk({63'd0, alarm_evt}, 64'h0, "R8 no alarm at 08 seconds");

    // R8 exact match in binary, hour mismatch then match
    bcd_mode = 1'b0;
    wr(4'd0, 8'h3B); wr(4'd2, 8'h00); wr(4'd4, 8'h02);
    wr(4'd1, 8'h00); wr(4'd3, 8'h01); wr(4'd5, 8'h03);
    tick();
    chk({63'd0, alarm_evt}, 64'h0, "R8 hour mismatch no alarm");
    wr(4'd0, 8'h3B); wr(4'd2, 8'h00); wr(4'd5, 8'h02);
    tick();
    chk({63'd0, alarm_evt}, 64'h1, "R8 exact match alarm");

    // R6 day of week wraps via full midnight in 24h binary
    wr(4'd0, 8'h3B); wr(4'd2, 8'h3B); wr(4'd4, 8'h17); wr(4'd6, 8'h07);
    tick();
    rd(4'd6, b); chk({56'd0, b}, 64'h01, "R6 day of week 7 -> 1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule